// File: doc/BRIEF.md
# Inter-Processor Interrupt Target Resolver

This block turns an inter-processor interrupt command into a mask of target local interrupt controllers. It holds a small table of targets. Each entry has an 8-bit physical ID, an 8-bit logical ID and a 2-bit logical-format code. A command is issued as two 32-bit words. The high word carries the destination. Writing the low word carries the delivery mode, the addressing mode and the shorthand, and it also fires the command. The source target index comes in on its own port at the same time as the low-word write. One cycle after the low-word write the block presents the resolved target mask with a one-cycle valid strobe.

For lowest-priority delivery the block narrows the match set down to exactly one target. It does this with per-target arbitration counters. A counter grows each time its target receives a lowest-priority interrupt, so repeated lowest-priority traffic spreads across the eligible targets. Rewriting a target's table entry counts as a reset of that target and clears its counter. Injecting the interrupt into the target is left to the logic that consumes the mask.

Top module: `ipi_dest_resolver`

## Requirements
- R1: After reset, `out_valid` is 0, `out_mask` is all zero and both command read-back words are zero. Every table entry is reset to physical ID 0, logical ID 0 and flat format, and every arbitration counter is reset to 0.
- R2: When low-word bit 11 is 0 (physical mode) and bits 19:18 are 0 (no shorthand), a target matches if the stored destination equals its physical ID. Destination 0xFF matches every target.
- R3: In logical mode (bit 11 = 1) with a format code of 0 (flat), a target matches when its logical ID ANDed with the destination is nonzero.
- R4: In logical mode with a format code of 1 (cluster), a target matches when the upper nibble of its logical ID equals the upper nibble of the destination and the bitwise AND of the two lower nibbles is nonzero.
- R5: A format code of 2 or 3 never produces a logical match.
- R6: Low-word bits 19:18 select the shorthand, and every shorthand other than 0 ignores the destination field. The codes are: 0 uses the destination; 1 matches only the source index; 2 matches all targets; 3 matches all targets except the source index.
- R7: `out_valid` is high in exactly the cycle after each low-word write and low otherwise. `out_mask` is zero whenever `out_valid` is low. A command with no matches still raises `out_valid`, with an all-zero mask.
- R8: When low-word bits 10:8 equal 1 (lowest priority), the mask holds exactly one bit. That bit is the matching target with the smallest arbitration counter, and ties go to the lowest index. With any other delivery mode the mask holds every match.
- R9: Each lowest-priority delivery increments the chosen target's counter by one, saturating at its maximum value. A table write to a target clears that target's counter.
- R10: `cmd_hi_rdata` returns only bits 31:24 of the last high-word write, with every other bit zero. `cmd_lo_rdata` returns the last low word with bit 12 (delivery status) always clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one target table entry; also clears that target's counter |
| cfg_idx | input | IDX_W | Target index for the table write |
| cfg_phys_id | input | 8 | Physical ID to store |
| cfg_log_id | input | 8 | Logical ID to store |
| cfg_fmt | input | 2 | Logical format code: 0 flat, 1 cluster, 2 and 3 invalid |
| cmd_hi_we | input | 1 | Write the high command word |
| cmd_hi_wdata | input | 32 | High command word; bits 31:24 are the destination |
| cmd_lo_we | input | 1 | Write the low command word and fire the command |
| cmd_lo_wdata | input | 32 | Low command word: 10:8 delivery mode, 11 logical, 19:18 shorthand |
| cmd_src | input | IDX_W | Index of the sending target, sampled with `cmd_lo_we` |
| cmd_hi_rdata | output | 32 | Read-back of the high command word |
| cmd_lo_rdata | output | 32 | Read-back of the low command word |
| out_valid | output | 1 | Strobe for one cycle after each command |
| out_mask | output | N_TGT | Resolved target mask |

## Verification
The bench sweeps all 256 destinations in physical, flat, cluster and invalid-format settings. These sweeps catch three kinds of fault:
- broadcast being applied in logical mode or dropped in physical mode;
- a cluster compare that ignores the nibble split;
- an invalid format that falls through to flat matching.

Every shorthand is paired with every source index, which exposes a self or all-but-self decode that uses the wrong target.

Long lowest-priority runs check that the choice rotates in order of counter value and index. A strict/non-strict compare slip would break the low-index tie rule, and a missing increment would keep picking one target. A mid-run table rewrite must pull the chosen target back to itself until its cleared counter catches up.

// File: rtl/ipi_res_pkg.sv
package ipi_res_pkg;

  // Low command word field positions
  localparam int DM_LSB      = 8;
  localparam int LOGICAL_BIT = 11;
  localparam int STATUS_BIT  = 12;
  localparam int SH_LSB      = 18;

  localparam logic [2:0] DM_LOWEST = 3'd1;

  localparam logic [1:0] FMT_FLAT    = 2'd0;
  localparam logic [1:0] FMT_CLUSTER = 2'd1;

  typedef enum logic [1:0] {
    SH_NONE    = 2'd0,
    SH_SELF    = 2'd1,
    SH_ALL_INC = 2'd2,
    SH_ALL_EXC = 2'd3
  } shorthand_e;

  function automatic logic phys_hit(input logic [7:0] id, input logic [7:0] dest);
    return (dest == 8'hFF) || (dest == id);
  endfunction

  function automatic logic logical_hit(input logic [1:0] fmt, input logic [7:0] lid,
                                       input logic [7:0] dest);
    logic r;
    case (fmt)
      FMT_FLAT:    r = |(lid & dest);
      FMT_CLUSTER: r = (lid[7:4] == dest[7:4]) && (|(lid[3:0] & dest[3:0]));
      default:     r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ipi_tgt_match.sv
module ipi_tgt_match
  import ipi_res_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int MY_IDX = 0
) (
  input  logic [7:0]       phys_id,
  input  logic [7:0]       log_id,
  input  logic [1:0]       fmt,
  input  logic [7:0]       dest,
  input  logic             logical,
  input  logic [1:0]       shorthand,
  input  logic [IDX_W-1:0] src,
  output logic             hit
);

  logic is_self;
  logic dest_hit;

  assign is_self  = (src == IDX_W'(MY_IDX));
  assign dest_hit = logical ? logical_hit(fmt, log_id, dest) : phys_hit(phys_id, dest);

  always_comb begin
    case (shorthand_e'(shorthand))
      SH_NONE:    hit = dest_hit;
      SH_SELF:    hit = is_self;
      SH_ALL_INC: hit = 1'b1;
      SH_ALL_EXC: hit = !is_self;
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ipi_arb_pick.sv
module ipi_arb_pick #(
  parameter int N_TGT = 4,
  parameter int ARB_W = 8
) (
  input  logic [N_TGT*ARB_W-1:0] cnt_flat,
  input  logic [N_TGT-1:0]       cand,
  output logic [N_TGT-1:0]       pick
);

  logic [ARB_W-1:0] best;
  logic             found;

  // Linear scan: strict less-than keeps the lowest index on a tie
  always_comb begin
    best  = '0;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N_TGT; i++) begin
      if (cand[i] && (!found || (cnt_flat[i*ARB_W +: ARB_W] < best))) begin
        best  = cnt_flat[i*ARB_W +: ARB_W];
        found = 1'b1;
        pick  = '0;
        pick[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_res_pkg::*;
#(
  parameter int N_TGT = 4,
  parameter int ARB_W = 8,
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [7:0]       cfg_phys_id,
  input  logic [7:0]       cfg_log_id,
  input  logic [1:0]       cfg_fmt,
  input  logic             cmd_hi_we,
  input  logic [31:0]      cmd_hi_wdata,
  input  logic             cmd_lo_we,
  input  logic [31:0]      cmd_lo_wdata,
  input  logic [IDX_W-1:0] cmd_src,
  output logic [31:0]      cmd_hi_rdata,
  output logic [31:0]      cmd_lo_rdata,
  output logic             out_valid,
  output logic [N_TGT-1:0] out_mask
);

  localparam logic [ARB_W-1:0] CNT_MAX = '1;

  logic [31:0] hi_q, lo_q;
  logic [7:0]  dest;
  logic [1:0]  sh;
  logic        logical;
  logic        is_lowest;

  logic [N_TGT-1:0]       hit_vec;
  logic [N_TGT-1:0]       pick_vec;
  logic [N_TGT-1:0]       nxt_mask;
  logic [N_TGT*ARB_W-1:0] arb_cnt_flat;
  logic                   lp_accept;

  assign dest      = hi_q[31:24];
  assign sh        = cmd_lo_wdata[SH_LSB +: 2];
  assign logical   = cmd_lo_wdata[LOGICAL_BIT];
  assign is_lowest = (cmd_lo_wdata[DM_LSB +: 3] == DM_LOWEST);

  // Command word registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (cmd_hi_we) hi_q <= cmd_hi_wdata & 32'hFF00_0000;
      if (cmd_lo_we) lo_q <= cmd_lo_wdata & ~(32'd1 << STATUS_BIT);
    end
  end

  assign cmd_hi_rdata = hi_q;
  assign cmd_lo_rdata = lo_q;

  // Per-target table, counter and match
  for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
    logic [7:0]       phys_q, log_q;
    logic [1:0]       fmt_q;
    logic [ARB_W-1:0] cnt_q;
    logic             sel_cfg;

    assign sel_cfg = cfg_we && (cfg_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        phys_q <= '0;
        log_q  <= '0;
        fmt_q  <= FMT_FLAT;
        cnt_q  <= '0;
      end else if (sel_cfg) begin
        phys_q <= cfg_phys_id;
        log_q  <= cfg_log_id;
        fmt_q  <= cfg_fmt;
        cnt_q  <= '0;
      end else if (lp_accept && pick_vec[i] && (cnt_q != CNT_MAX)) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end

    assign arb_cnt_flat[i*ARB_W +: ARB_W] = cnt_q;

    ipi_tgt_match #(.IDX_W(IDX_W), .MY_IDX(i)) u_match (
      .phys_id   (phys_q),
      .log_id    (log_q),
      .fmt       (fmt_q),
      .dest      (dest),
      .logical   (logical),
      .shorthand (sh),
      .src       (cmd_src),
      .hit       (hit_vec[i])
    );
  end

  ipi_arb_pick #(.N_TGT(N_TGT), .ARB_W(ARB_W)) u_pick (
    .cnt_flat (arb_cnt_flat),
    .cand     (hit_vec),
    .pick     (pick_vec)
  );

  assign lp_accept = cmd_lo_we && is_lowest && (|pick_vec);
  assign nxt_mask  = is_lowest ? pick_vec : hit_vec;

  // Result register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= cmd_lo_we;
      out_mask  <= cmd_lo_we ? nxt_mask : '0;
    end
  end

endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk #(
  parameter int N_TGT = 4,
  parameter int ARB_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_lo_we,
  input logic [31:0]            cmd_lo_wdata,
  input logic [31:0]            cmd_hi_rdata,
  input logic [31:0]            cmd_lo_rdata,
  input logic                   out_valid,
  input logic [N_TGT-1:0]       out_mask,
  input logic                   lp_accept,
  input logic [N_TGT*ARB_W-1:0] arb_cnt_flat
);

  // R7
  valid_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lo_we |=> out_valid);

  // R7
  valid_only_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_lo_we |=> (!out_valid && out_mask == '0));

  // R8
  lowest_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_we && cmd_lo_wdata[10:8] == 3'd1) |=> ($countones(out_mask) <= 1));

  // R8
  lowest_accept_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_accept |=> $onehot0(out_mask) && (out_mask != '0));

  // R6
  all_inc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lo_we && cmd_lo_wdata[19:18] == 2'd2 && cmd_lo_wdata[10:8] != 3'd1)
      |=> (&out_mask));

  // R9
  counters_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_accept && !cmd_lo_we) |=> (arb_cnt_flat <= $past(arb_cnt_flat) ||
                                    arb_cnt_flat == $past(arb_cnt_flat)));

  // R10
  readback_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hi_rdata[23:0] == 24'd0) && !cmd_lo_rdata[12]);

endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.N_TGT(N_TGT), .ARB_W(ARB_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_lo_we    (cmd_lo_we),
  .cmd_lo_wdata (cmd_lo_wdata),
  .cmd_hi_rdata (cmd_hi_rdata),
  .cmd_lo_rdata (cmd_lo_rdata),
  .out_valid    (out_valid),
  .out_mask     (out_mask),
  .lp_accept    (lp_accept),
  .arb_cnt_flat (arb_cnt_flat)
);

// File: tb/ipi_dest_resolver_bench.sv
module ipi_dest_resolver_bench;

  localparam int N = 4;
  localparam int W = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [W-1:0]  cfg_idx = '0;
  logic [7:0]    cfg_phys_id = '0;
  logic [7:0]    cfg_log_id = '0;
  logic [1:0]    cfg_fmt = '0;
  logic          cmd_hi_we = 1'b0;
  logic [31:0]   cmd_hi_wdata = '0;
  logic          cmd_lo_we = 1'b0;
  logic [31:0]   cmd_lo_wdata = '0;
  logic [W-1:0]  cmd_src = '0;
  logic [31:0]   cmd_hi_rdata, cmd_lo_rdata;
  logic          out_valid;
  logic [N-1:0]  out_mask;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Bench-side model state
  logic [7:0] m_phys [N];
  logic [7:0] m_lid  [N];
  logic [1:0] m_fmt  [N];
  int         m_cnt  [N];
  logic [7:0] m_dest;

  always #4 clk = ~clk;

  ipi_dest_resolver u_ipi_dest_resolver (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_phys_id(cfg_phys_id),
    .cfg_log_id(cfg_log_id), .cfg_fmt(cfg_fmt),
    .cmd_hi_we(cmd_hi_we), .cmd_hi_wdata(cmd_hi_wdata),
    .cmd_lo_we(cmd_lo_we), .cmd_lo_wdata(cmd_lo_wdata), .cmd_src(cmd_src),
    .cmd_hi_rdata(cmd_hi_rdata), .cmd_lo_rdata(cmd_lo_rdata),
    .out_valid(out_valid), .out_mask(out_mask)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_tgt(input int i, input logic [7:0] p, input logic [7:0] l, input logic [1:0] f);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = W'(i); cfg_phys_id = p; cfg_log_id = l; cfg_fmt = f;
    @(negedge clk);
    cfg_we = 1'b0;
    m_phys[i] = p; m_lid[i] = l; m_fmt[i] = f; m_cnt[i] = 0;
  endtask

  task automatic set_dest(input logic [7:0] d);
    @(negedge clk);
    cmd_hi_we = 1'b1; cmd_hi_wdata = {d, 24'h5A5A5A};
    @(negedge clk);
    cmd_hi_we = 1'b0;
    m_dest = d;
  endtask

  function automatic logic [31:0] lo_word(input int dm, input int lg, input int sh);
    return (32'(sh) << 18) | (32'(lg) << 11) | (32'(dm) << 8) | 32'h0000_1042;
  endfunction

  // Independent restatement of the matching rules
  function automatic logic [N-1:0] model_mask(input int dm, input int lg, input int sh, input int src);
    logic [N-1:0] m;
    int best;
    m = '0;
    for (int i = 0; i < N; i++) begin
      logic h;
      logic [7:0] a;
      a = m_lid[i] & m_dest;
      if (sh == 1)      h = (i == src);
      else if (sh == 2) h = 1'b1;
      else if (sh == 3) h = (i != src);
      else if (lg == 0) h = (m_dest == 8'hFF) || (m_phys[i] == m_dest);
      else if (m_fmt[i] == 2'd0) h = (a != 8'h00);
      else if (m_fmt[i] == 2'd1) h = (m_lid[i][7:4] == m_dest[7:4]) && (a[3:0] != 4'h0);
      else h = 1'b0;
      m[i] = h;
    end
    if (dm == 1) begin
      best = -1;
      for (int i = N - 1; i >= 0; i--)
        if (m[i] && (best < 0 || m_cnt[i] <= m_cnt[best])) best = i;
      m = '0;
      if (best >= 0) begin
        m[best] = 1'b1;
        if (m_cnt[best] < 255) m_cnt[best]++;
      end
    end
    return m;
  endfunction

  task automatic fire(input string req, input int dm, input int lg, input int sh, input int src);
    logic [N-1:0] exp;
    exp = model_mask(dm, lg, sh, src);
    @(negedge clk);
    cmd_lo_we = 1'b1; cmd_lo_wdata = lo_word(dm, lg, sh); cmd_src = W'(src);
    @(negedge clk);
    cmd_lo_we = 1'b0;
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check(req, 32'(out_mask), 32'(exp));
    @(negedge clk);
    check("R7 strobe drop", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_phys[i] = 0; m_lid[i] = 0; m_fmt[i] = 0; m_cnt[i] = 0;
    end
    m_dest = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(out_valid), 32'd0);
    check("R1 mask", 32'(out_mask), 32'd0);
    check("R1 hi", cmd_hi_rdata, 32'd0);
    check("R1 lo", cmd_lo_rdata, 32'd0);
    // R1 reset table: phys 0 for all, dest 0 matches all
    fire("R1 table", 0, 0, 0, 0);

    // R10 read-back
    set_dest(8'hAB);
    check("R10 hi", cmd_hi_rdata, 32'hAB00_0000);
    fire("R10 fire", 0, 0, 0, 0);
    check("R10 lo", cmd_lo_rdata, lo_word(0, 0, 0) & ~32'h1000);

    set_tgt(0, 8'h03, 8'h01, 2'd0);
    set_tgt(1, 8'h41, 8'h12, 2'd0);
    set_tgt(2, 8'h03, 8'h14, 2'd0);
    set_tgt(3, 8'hFE, 8'h2C, 2'd0);

    // R2 physical sweep, R3 flat sweep
    for (int d = 0; d < 256; d++) begin
      set_dest(8'(d));
      fire("R2 physical", 0, 0, 0, d % N);
      fire("R3 flat", 0, 1, 0, 0);
    end

    // R4 cluster sweep, mixed with one flat target
    set_tgt(0, 8'h03, 8'h11, 2'd1);
    set_tgt(1, 8'h41, 8'h12, 2'd1);
    set_tgt(2, 8'h03, 8'h23, 2'd1);
    set_tgt(3, 8'hFE, 8'h2C, 2'd0);
    for (int d = 0; d < 256; d++) begin
      set_dest(8'(d));
      fire("R4 cluster", 0, 1, 0, 0);
    end

    // R5 invalid formats
    set_tgt(0, 8'h03, 8'hFF, 2'd2);
    set_tgt(1, 8'h41, 8'hFF, 2'd3);
    set_tgt(2, 8'h03, 8'hFF, 2'd2);
    set_tgt(3, 8'hFE, 8'hFF, 2'd3);
    for (int d = 0; d < 256; d++) begin
      set_dest(8'(d));
      fire("R5 invalid fmt", 0, 1, 0, 0);
    end

    // R6 shorthands with every source, destination must not matter
    set_dest(8'h77);
    for (int sh = 1; sh < 4; sh++)
      for (int s = 0; s < N; s++) begin
        fire("R6 shorthand", 0, 0, sh, s);
        fire("R6 shorthand logical", 0, 1, sh, s);
      end

    // R7 no-match command
    set_dest(8'h55);
    fire("R7 empty", 0, 0, 0, 0);

    // R8 / R9 lowest priority rotation
    set_tgt(0, 8'h03, 8'h11, 2'd1);
    set_tgt(1, 8'h41, 8'h12, 2'd1);
    set_tgt(2, 8'h03, 8'h23, 2'd1);
    set_tgt(3, 8'hFE, 8'h2C, 2'd0);
    set_dest(8'hFF);
    for (int k = 0; k < 10; k++) fire("R8 lowest broadcast", 1, 0, 0, 0);
    set_tgt(2, 8'h03, 8'h23, 2'd1);   // R9 counter clear
    for (int k = 0; k < 8; k++) fire("R9 after clear", 1, 0, 2, 1);
    set_dest(8'h03);
    for (int k = 0; k < 6; k++) fire("R8 lowest subset", 1, 0, 0, 0);
    for (int k = 0; k < 6; k++) fire("R8 lowest all-but-self", 1, 0, 3, 2);
    set_dest(8'h55);
    fire("R8 lowest none", 1, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule